// File: doc/BRIEF.md
# Five-Phase Multicycle Load-Store Processor Core

This core runs a small load-store instruction set without overlap between instructions. Every 32-bit instruction word passes through five sequential phases: fetch, decode with operand read, execute, memory access and write-back. Each phase takes one clock cycle, so every instruction takes exactly five cycles. A phase that an instruction does not need is spent as an idle cycle. The datapath is 16 bits wide and has 32 general registers. Register 0 is hard-wired to zero.

Instructions and data live in separate memories. Both are attached through plain combinational read ports. The core raises `imem_re` in the fetch cycle and expects `imem_rdata` to be valid in that same cycle. It raises `dmem_re` or `dmem_we` in the memory cycle. A store is committed by the memory at the clock edge that closes the memory cycle. Load data must be valid in the same cycle as `dmem_re`. Neither port has a handshake or back-pressure: a memory must answer in the cycle it is addressed.

The next program counter is computed at the end of the execute phase. It is one of three values: the sequential address, a branch target relative to the sequential address, or an absolute jump target.

Top module: `mc16_core`

## Requirements
- R1: While `rst_n` is low the program counter is cleared and the core sits in the fetch phase. In the first cycle after release, `imem_addr` is 0, `imem_re` is 1, and `dmem_we` and `dmem_re` are 0.
- R2: The phases run fetch, decode, execute, memory, write-back and back to fetch. `imem_re` is high exactly once every five cycles, starting in cycle 0 after reset. A store at program index k asserts `dmem_we` in cycle 5k+3.
- R3: A word with bits [31:26]=0 and bits [10:6]=0 is a register-type operation. Bits [25:21] give the first source register, [20:16] the second source and [15:11] the destination. The function field in bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. Results wrap modulo 2^16. Any other function value, or a nonzero bits [10:6], writes nothing.
- R4: Opcode 0x08 (add-immediate) writes rs + sign-extended bits [15:0] to the register named in bits [20:16].
- R5: Opcode 0x2B (store) and opcode 0x23 (load) form the byte address rs + sign-extended bits [15:0]. A store writes register rt. A load writes the returned data into rt in the write-back phase.
- R6: Opcode 0x04 (branch-if-equal) compares rs with rt. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 0x02 (jump) sets the next PC to the upper 4 bits of PC+4 joined with bits [25:0] and two zero bits.
- R8: Register 0 reads as zero. Writes to register 0 have no effect.
- R9: At most one of `imem_re`, `dmem_re` and `dmem_we` is high in any cycle. `imem_addr` stays word-aligned and changes only at the edge that closes an execute phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_re | output | 1 | Instruction read strobe (fetch phase) |
| imem_addr | output | 32 | Instruction byte address (program counter) |
| imem_rdata | input | 32 | Instruction word, valid in the same cycle |
| dmem_re | output | 1 | Data read strobe (load, memory phase) |
| dmem_we | output | 1 | Data write strobe (store, memory phase) |
| dmem_addr | output | 16 | Data byte address |
| dmem_wdata | output | 16 | Store data |
| dmem_rdata | input | 16 | Load data, valid in the same cycle |

## Verification
Some properties are checked by assertions on every cycle. These are the fixed phase order, the single fetch strobe per instruction, the mutual exclusion of the three memory strobes, the word alignment of the program counter, the rule that the PC moves only after execute, and the fetch state after reset. The arithmetic is covered only by the bench's directed programs, because checking it needs a known program and expected memory contents. Those programs cover wrap-around arithmetic, sign extension of immediates and offsets, load-to-use through the register file, taken and untaken branches (including a backward one), absolute jumps and the discarding of writes to register 0. The bench reads every result out through stores to data memory.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  typedef enum logic [2:0] {
    PH_IF  = 3'd0,
    PH_ID  = 3'd1,
    PH_EX  = 3'd2,
    PH_MEM = 3'd3,
    PH_WB  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } alu_op_e;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;

  typedef struct packed {
    alu_op_e alu_op;
    logic    use_imm;
    logic    reg_wr;
    logic    dst_rt;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    jump;
  } ctrl_t;

endpackage

// File: rtl/mc16_decode.sv
module mc16_decode
  import mc16_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (shamt == 5'd0) begin
          unique case (funct)
            FN_ADD:  begin ctrl.alu_op = ALU_ADD; ctrl.reg_wr = 1'b1; end
            FN_SUB:  begin ctrl.alu_op = ALU_SUB; ctrl.reg_wr = 1'b1; end
            FN_AND:  begin ctrl.alu_op = ALU_AND; ctrl.reg_wr = 1'b1; end
            FN_OR:   begin ctrl.alu_op = ALU_OR;  ctrl.reg_wr = 1'b1; end
            default: ctrl.reg_wr = 1'b0;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.dst_rt  = 1'b1;
      end
      OP_LOAD: begin
        ctrl.use_imm = 1'b1;
        ctrl.reg_wr  = 1'b1;
        ctrl.dst_rt  = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.alu_op = ALU_SUB;
        ctrl.branch = 1'b1;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_idx,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_a_val,
  output logic [XLEN-1:0] rd_b_val,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_val
);

  logic [NREG-1:0][XLEN-1:0] view;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign view[i] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= '0;
        else if (wr_en && wr_idx == AW'(i))    q <= wr_val;
      end
      assign view[i] = q;
    end
  end

  assign rd_a_val = view[rd_a_idx];
  assign rd_b_val = view[rd_b_idx];

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res,
  output logic            is_zero
);

  always_comb begin
    unique case (op)
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/mc16_pcunit.sv
module mc16_pcunit #(
  parameter int PC_W = 32
) (
  input  logic [PC_W-1:0] seq_pc,
  input  logic [15:0]     offset,
  input  logic [25:0]     target,
  input  logic            take_branch,
  input  logic            take_jump,
  output logic [PC_W-1:0] next_pc
);

  logic [PC_W-1:0] rel_pc;
  logic [PC_W-1:0] abs_pc;

  assign rel_pc = seq_pc + PC_W'(signed'({offset, 2'b00}));
  assign abs_pc = {seq_pc[PC_W-1:28], target, 2'b00};

  always_comb begin
    if (take_jump)        next_pc = abs_pc;
    else if (take_branch) next_pc = rel_pc;
    else                  next_pc = seq_pc;
  end

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int NREG = 32,
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            imem_re,
  output logic [PC_W-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic            dmem_re,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int AW = $clog2(NREG);

  phase_e          phase;
  logic [PC_W-1:0] pc_q, seq_q, pc_next;
  logic [31:0]     ir_q;
  logic [XLEN-1:0] a_q, b_q, res_q, ld_q;
  logic [XLEN-1:0] rf_a, rf_b, imm_x, alu_b, alu_y;
  logic            alu_z;
  ctrl_t           ctrl;
  logic [AW-1:0]   wr_idx;
  logic [XLEN-1:0] wr_val;
  logic            wr_en;

  mc16_decode u_dec (
    .opcode (ir_q[31:26]),
    .shamt  (ir_q[10:6]),
    .funct  (ir_q[5:0]),
    .ctrl   (ctrl)
  );

  assign wr_idx = ctrl.dst_rt ? AW'(ir_q[20:16]) : AW'(ir_q[15:11]);
  assign wr_val = ctrl.mem_rd ? ld_q : res_q;
  assign wr_en  = (phase == PH_WB) && ctrl.reg_wr;

  mc16_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (AW'(ir_q[25:21])),
    .rd_b_idx (AW'(ir_q[20:16])),
    .rd_a_val (rf_a),
    .rd_b_val (rf_b),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_val   (wr_val)
  );

  assign imm_x = XLEN'(signed'(ir_q[15:0]));
  assign alu_b = ctrl.use_imm ? imm_x : b_q;

  mc16_alu #(.XLEN(XLEN)) u_alu (
    .opa     (a_q),
    .opb     (alu_b),
    .op      (ctrl.alu_op),
    .res     (alu_y),
    .is_zero (alu_z)
  );

  mc16_pcunit #(.PC_W(PC_W)) u_pc (
    .seq_pc      (seq_q),
    .offset      (ir_q[15:0]),
    .target      (ir_q[25:0]),
    .take_branch (ctrl.branch && alu_z),
    .take_jump   (ctrl.jump),
    .next_pc     (pc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IF;
      pc_q  <= '0;
      seq_q <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      ld_q  <= '0;
    end else begin
      unique case (phase)
        PH_IF: begin
          ir_q  <= imem_rdata;
          phase <= PH_ID;
        end
        PH_ID: begin
          a_q   <= rf_a;
          b_q   <= rf_b;
          seq_q <= pc_q + PC_W'(4);
          phase <= PH_EX;
        end
        PH_EX: begin
          res_q <= alu_y;
          pc_q  <= pc_next;
          phase <= PH_MEM;
        end
        PH_MEM: begin
          if (ctrl.mem_rd) ld_q <= dmem_rdata;
          phase <= PH_WB;
        end
        PH_WB:   phase <= PH_IF;
        default: phase <= PH_IF;
      endcase
    end
  end

  assign imem_re    = (phase == PH_IF);
  assign imem_addr  = pc_q;
  assign dmem_re    = (phase == PH_MEM) && ctrl.mem_rd;
  assign dmem_we    = (phase == PH_MEM) && ctrl.mem_wr;
  assign dmem_addr  = res_q;
  assign dmem_wdata = b_q;

endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
  import mc16_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input phase_e          phase,
  input logic            imem_re,
  input logic [PC_W-1:0] imem_addr,
  input logic            dmem_re,
  input logic            dmem_we
);

  // R1
  reset_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (imem_addr == '0) && imem_re && !dmem_we && !dmem_re);

  // R2
  if_to_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IF) |=> (phase == PH_ID));

  // R2
  wb_to_if_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WB) |=> (phase == PH_IF) && imem_re);

  // R2
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_re |=> !imem_re);

  // R5
  mem_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_re || dmem_we) |=> (phase == PH_WB));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({imem_re, dmem_re, dmem_we}));

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_EX) |=> $stable(imem_addr));

  // R9
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);

endmodule

bind mc16_core mc16_core_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .imem_re   (imem_re),
  .imem_addr (imem_addr),
  .dmem_re   (dmem_re),
  .dmem_we   (dmem_we)
);

// File: tb/mc16_core_test.sv
module mc16_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_re, dmem_re, dmem_we;
  logic [31:0] imem_addr, imem_rdata;
  logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;

  logic [31:0] imem  [64];
  logic [15:0] dmem  [64];
  logic [15:0] dinit [64];
  logic        load_d = 1'b0;
  int          cyc;
  int          first_we;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  mc16_core uut (
    .clk(clk), .rst_n(rst_n),
    .imem_re(imem_re), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_re(dmem_re), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[6:1]];

  always @(posedge clk) begin
    if (load_d) begin
      for (int i = 0; i < 64; i++) dmem[i] <= dinit[i];
    end else if (dmem_we) begin
      dmem[dmem_addr[6:1]] <= dmem_wdata;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc <= 0;
      first_we <= -1;
    end else begin
      cyc <= cyc + 1;
      if (dmem_we && first_we == -1) first_we <= cyc;
    end
  end

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] j_ins(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin
      imem[i]  = 32'h0;
      dinit[i] = 16'hAAAA;
    end
  endtask

  task automatic start_prog();
    rst_n  = 1'b0;
    load_d = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    load_d = 1'b0;
    rst_n  = 1'b1;
  endtask

  task automatic t_reset_and_alu();
    clear_prog();
    imem[0]  = i_ins(6'h08, 0, 1, 16'd12);
    imem[1]  = i_ins(6'h08, 0, 2, 16'hFFFA);
    imem[2]  = r_ins(1, 2, 3, 6'h20);
    imem[3]  = r_ins(1, 2, 4, 6'h22);
    imem[4]  = r_ins(1, 2, 5, 6'h24);
    imem[5]  = r_ins(1, 2, 6, 6'h25);
    imem[6]  = i_ins(6'h2B, 0, 3, 16'd0);
    imem[7]  = i_ins(6'h2B, 0, 4, 16'd2);
    imem[8]  = i_ins(6'h2B, 0, 5, 16'd4);
    imem[9]  = i_ins(6'h2B, 0, 6, 16'd6);
    imem[10] = j_ins(10);
    start_prog();
    // R1: state right after reset release
    check("R1 imem_addr", imem_addr, 32'h0);
    check("R1 imem_re", imem_re, 1);
    check("R1 dmem strobes", {dmem_we, dmem_re}, 0);
    // R2: one fetch strobe every five cycles
    for (int c = 0; c < 15; c++) begin
      check("R2 fetch pattern", imem_re, (c % 5 == 0));
      @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check("R2 store cycle", first_we, 33);
    check("R3 add wrap", dmem[0], 16'h0006);
    check("R3 sub", dmem[1], 16'h0012);
    check("R3 and", dmem[2], 16'h0008);
    check("R4 addi sign-ext via or", dmem[3], 16'hFFFE);
  endtask

  task automatic t_reg_zero();
    clear_prog();
    imem[0] = i_ins(6'h08, 0, 0, 16'd7);
    imem[1] = r_ins(0, 0, 1, 6'h20);
    imem[2] = i_ins(6'h2B, 0, 0, 16'd8);
    imem[3] = i_ins(6'h2B, 0, 1, 16'd10);
    imem[4] = r_ins(0, 0, 7, 6'h3F);
    imem[5] = i_ins(6'h2B, 0, 7, 16'd12);
    imem[6] = j_ins(6);
    start_prog();
    repeat (45) @(negedge clk);
    check("R8 r0 stored", dmem[4], 16'h0000);
    check("R8 r0 read", dmem[5], 16'h0000);
    check("R3 unknown funct no write", dmem[6], 16'h0000);
  endtask

  task automatic t_load_store();
    clear_prog();
    dinit[15] = 16'hBEEF;
    imem[0] = i_ins(6'h08, 0, 1, 16'h1234);
    imem[1] = i_ins(6'h2B, 0, 1, 16'd20);
    imem[2] = i_ins(6'h23, 0, 2, 16'd20);
    imem[3] = i_ins(6'h08, 2, 3, 16'd1);
    imem[4] = i_ins(6'h2B, 0, 3, 16'd22);
    imem[5] = i_ins(6'h08, 0, 4, 16'd16);
    imem[6] = i_ins(6'h2B, 4, 1, 16'hFFFC);
    imem[7] = i_ins(6'h23, 0, 5, 16'd30);
    imem[8] = i_ins(6'h2B, 0, 5, 16'd32);
    imem[9] = j_ins(9);
    start_prog();
    repeat (60) @(negedge clk);
    check("R5 store", dmem[10], 16'h1234);
    check("R5 load then use", dmem[11], 16'h1235);
    check("R5 negative offset", dmem[6], 16'h1234);
    check("R5 untouched word", dmem[7], 16'hAAAA);
    check("R5 load preset", dmem[16], 16'hBEEF);
  endtask

  task automatic t_branch();
    clear_prog();
    imem[0] = i_ins(6'h08, 0, 1, 16'd3);
    imem[1] = i_ins(6'h08, 0, 2, 16'd3);
    imem[2] = i_ins(6'h04, 1, 2, 16'd2);
    imem[3] = i_ins(6'h2B, 0, 1, 16'd40);
    imem[4] = i_ins(6'h2B, 0, 1, 16'd40);
    imem[5] = i_ins(6'h04, 1, 0, 16'd1);
    imem[6] = i_ins(6'h2B, 0, 2, 16'd42);
    imem[7] = i_ins(6'h04, 0, 0, 16'hFFFF);
    start_prog();
    repeat (50) @(negedge clk);
    check("R6 taken skips", dmem[20], 16'hAAAA);
    check("R6 not taken", dmem[21], 16'h0003);
    check("R6 backward self-branch", imem_addr, 32'd28);
  endtask

  task automatic t_jump();
    clear_prog();
    imem[0] = j_ins(3);
    imem[1] = i_ins(6'h2B, 0, 0, 16'd48);
    imem[2] = i_ins(6'h2B, 0, 0, 16'd48);
    imem[3] = i_ins(6'h08, 0, 1, 16'd9);
    imem[4] = i_ins(6'h2B, 0, 1, 16'd50);
    imem[5] = j_ins(5);
    start_prog();
    repeat (40) @(negedge clk);
    check("R7 skipped", dmem[24], 16'hAAAA);
    check("R7 target reached", dmem[25], 16'h0009);
    check("R7 jump pc", imem_addr, 32'd20);
  endtask

  initial begin
    t_reset_and_alu();
    t_reg_zero();
    t_load_store();
    t_branch();
    t_jump();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule